// File: doc/BRIEF.md
# Slope-Aware Sample Linearity Corrector

This block cleans up distortion in a stream of 14-bit signed samples where the error depends on how fast the signal is moving as well as on its level. It estimates the local slope with a fixed seven-tap antisymmetric differentiator. From the centre sample and its slope it forms six low-order product terms. Each term is scaled by its own programmable coefficient, and the rounded sum is added to the centre sample. One sample is taken per clock whenever `in_valid` is high.

Coefficients are loaded through a small write port (select plus data). They are meant to be changed while the pipeline is idle. With every coefficient at zero the block is an exact delay line. The latency from an accepted input to its corrected output is six clocks. The output is the corrected value of the sample taken three accepted samples earlier.

Top module: `dyn_lin_corr`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `out_sample` is 0 and all six coefficients are 0.
- R2: `out_valid` equals `in_valid` delayed by exactly six clocks. Clocks without `in_valid` do not advance the sample history.
- R3: The slope s is computed from the history x[n]..x[n-6], where x[n] is the newest sample. It is raw = 45(x[n-2]-x[n-4]) - 9(x[n-1]-x[n-5]) + (x[n]-x[n-6]), then s = sat14((raw*17) >>> 10). The centre sample is x = x[n-3].
- R4: Terms are taken as Q1.15 values saturated to 16 bits. Coefficient select 0 is x² = sat16((x·x)>>>11). Select 1 is x³ = sat16((x²·x)>>>13). Select 2 is s·x² = sat16((x²·s)>>>13). Select 3 is s² = sat16((s·s)>>>11). Select 4 is x·s² = sat16((s²·x)>>>13). Select 5 is x·s = sat16((x·s)>>>11).
- R5: The correction is (Σ c_k·term_k + 2^16) >>> 17, with c_k the signed 16-bit coefficients.
- R6: With all coefficients zero, each output equals its centre sample exactly.
- R7: The output is x + correction, saturated to the range -8192..8191.
- R8: A write with `coef_we` high stores `coef_wdata` into coefficient `coef_sel` at the clock edge. Writes with select 6 or 7 change nothing.
- R9: After reset the sample history holds zeros, so the first slopes treat the samples before the first input as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this clock |
| in_sample | input | 14 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 3 | Coefficient index, 0..5 valid |
| coef_wdata | input | 16 | Signed coefficient value |
| out_valid | output | 1 | Output sample present |
| out_sample | output | 14 | Signed corrected sample |

## Verification
A wrong slope or a misaligned centre tap leaves pure delay behaviour intact. It shows up only once a coefficient on a slope-bearing term is non-zero, and then on the first valid output six clocks after the fault. For that reason each term is driven alone with a fast triangle wave. A stale history or valid register shows as a shifted or missing output within the same six-clock window. The bench model predicts every output and compares it on every cycle, so a single bad sample is reported at once.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
package dlc_pkg;
  localparam int DATA_W   = 14;
  localparam int PROD_W   = 16;
  localparam int COEF_W   = 16;
  localparam int NTERM    = 6;
  localparam int TAPS     = 7;
  localparam int CENTRE   = (TAPS - 1) / 2;
  localparam int SEL_W    = 3;
  localparam int FRAC_IN  = DATA_W - 1;
  localparam int FRAC_P   = PROD_W - 1;
  localparam int SQ_SH    = 2 * FRAC_IN - FRAC_P;
  localparam int CUBE_SH  = FRAC_IN;
  localparam int OUT_SH   = 2 * FRAC_P - FRAC_IN;
  localparam int SLOPE_MUL = 17;
  localparam int SLOPE_SH  = 10;
  localparam int ACC_W    = 2 * PROD_W + 8;

  typedef logic signed [DATA_W-1:0] samp_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [COEF_W-1:0] coef_t;

  typedef enum int {
    T_XX  = 0,
    T_XXX = 1,
    T_SXX = 2,
    T_SS  = 3,
    T_XSS = 4,
    T_XS  = 5
  } term_e;

  localparam logic signed [47:0] SAMP_MAX = 48'sd8191;
  localparam logic signed [47:0] SAMP_MIN = -48'sd8192;
  localparam logic signed [47:0] PROD_MAX = 48'sd32767;
  localparam logic signed [47:0] PROD_MIN = -48'sd32768;

  function automatic samp_t sat_samp(input logic signed [47:0] v);
    logic signed [47:0] c;
    c = v;
    if (v > SAMP_MAX) c = SAMP_MAX;
    if (v < SAMP_MIN) c = SAMP_MIN;
    return c[DATA_W-1:0];
  endfunction

  function automatic prod_t sat_prod(input logic signed [47:0] v);
    logic signed [47:0] c;
    c = v;
    if (v > PROD_MAX) c = PROD_MAX;
    if (v < PROD_MIN) c = PROD_MIN;
    return c[PROD_W-1:0];
  endfunction
endpackage

// File: rtl/dlc_slope.sv
`timescale 1ns/1ps
module dlc_slope
  import dlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  samp_t in_sample,
  output logic  v_o,
  output samp_t x_o,
  output samp_t s_o
);
  samp_t hist_q [TAPS];
  samp_t hist_d [TAPS];
  logic  fill_q;
  logic  v_q;
  samp_t x_q, s_q;
  samp_t x_d, s_d;
  logic signed [47:0] hx [TAPS];
  logic signed [47:0] raw, scaled;

  // history: next state
  always_comb begin
    for (int k = 0; k < TAPS; k++) hist_d[k] = hist_q[k];
    if (in_valid) begin
      hist_d[0] = in_sample;
      for (int k = 1; k < TAPS; k++) hist_d[k] = hist_q[k-1];
    end
  end

  // differentiator and scaling
  always_comb begin
    for (int k = 0; k < TAPS; k++) hx[k] = 48'(hist_q[k]);
    raw = 48'sd45 * (hx[CENTRE-1] - hx[CENTRE+1])
        - 48'sd9  * (hx[CENTRE-2] - hx[CENTRE+2])
        +           (hx[CENTRE-3] - hx[CENTRE+3]);
    scaled = (raw * 48'(SLOPE_MUL)) >>> SLOPE_SH;
    s_d = sat_samp(scaled);
    x_d = hist_q[CENTRE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) hist_q[k] <= '0;
      fill_q <= 1'b0;
      v_q    <= 1'b0;
      x_q    <= '0;
      s_q    <= '0;
    end else begin
      for (int k = 0; k < TAPS; k++) hist_q[k] <= hist_d[k];
      fill_q <= in_valid;
      v_q    <= fill_q;
      if (fill_q) begin
        x_q <= x_d;
        s_q <= s_d;
      end
    end
  end

  assign v_o = v_q;
  assign x_o = x_q;
  assign s_o = s_q;

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (hist_q[0] == $past(hist_q[0]) && hist_q[TAPS-1] == $past(hist_q[TAPS-1]))); // R2
endmodule

// File: rtl/dlc_terms.sv
`timescale 1ns/1ps
module dlc_terms
  import dlc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  v_i,
  input  samp_t x_i,
  input  samp_t s_i,
  output logic  v_o,
  output samp_t x_o,
  output prod_t p_o [NTERM]
);
  logic  v3_q, v4_q;
  samp_t x3_q, s3_q, x4_q;
  prod_t sqx_q, sqs_q, xs_q;
  prod_t sqx_d, sqs_d, xs_d;
  prod_t p_q [NTERM];
  prod_t p_d [NTERM];

  // second-order terms
  always_comb begin
    sqx_d = sat_prod((48'(x_i) * 48'(x_i)) >>> SQ_SH);
    sqs_d = sat_prod((48'(s_i) * 48'(s_i)) >>> SQ_SH);
    xs_d  = sat_prod((48'(x_i) * 48'(s_i)) >>> SQ_SH);
  end

  // third-order terms, term vector ordered by coefficient select
  always_comb begin
    p_d[T_XX]  = sqx_q;
    p_d[T_SS]  = sqs_q;
    p_d[T_XS]  = xs_q;
    p_d[T_XXX] = sat_prod((48'(sqx_q) * 48'(x3_q)) >>> CUBE_SH);
    p_d[T_SXX] = sat_prod((48'(sqx_q) * 48'(s3_q)) >>> CUBE_SH);
    p_d[T_XSS] = sat_prod((48'(sqs_q) * 48'(x3_q)) >>> CUBE_SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v3_q  <= 1'b0;
      v4_q  <= 1'b0;
      x3_q  <= '0;
      s3_q  <= '0;
      x4_q  <= '0;
      sqx_q <= '0;
      sqs_q <= '0;
      xs_q  <= '0;
      for (int k = 0; k < NTERM; k++) p_q[k] <= '0;
    end else begin
      v3_q <= v_i;
      v4_q <= v3_q;
      if (v_i) begin
        x3_q  <= x_i;
        s3_q  <= s_i;
        sqx_q <= sqx_d;
        sqs_q <= sqs_d;
        xs_q  <= xs_d;
      end
      if (v3_q) begin
        x4_q <= x3_q;
        for (int k = 0; k < NTERM; k++) p_q[k] <= p_d[k];
      end
    end
  end

  assign v_o = v4_q;
  assign x_o = x4_q;
  always_comb for (int k = 0; k < NTERM; k++) p_o[k] = p_q[k];

  AST_SQUARE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    v3_q |-> (!sqx_q[PROD_W-1] && !sqs_q[PROD_W-1])); // R4
endmodule

// File: rtl/dlc_weight.sv
`timescale 1ns/1ps
module dlc_weight
  import dlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coef_we,
  input  logic [SEL_W-1:0] coef_sel,
  input  coef_t            coef_wdata,
  input  logic             v_i,
  input  samp_t            x_i,
  input  prod_t            p_i [NTERM],
  output logic             v_o,
  output samp_t            x_o,
  output logic signed [ACC_W-1:0] acc_o
);
  coef_t coef_q [NTERM];
  coef_t coef_d [NTERM];
  logic  v_q;
  samp_t x_q;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic coef_zero;

  // coefficient bank: next state
  always_comb begin
    for (int k = 0; k < NTERM; k++) coef_d[k] = coef_q[k];
    if (coef_we) begin
      for (int k = 0; k < NTERM; k++)
        if (int'(coef_sel) == k) coef_d[k] = coef_wdata;
    end
  end

  // weighted sum
  always_comb begin
    acc_d = '0;
    coef_zero = 1'b1;
    for (int k = 0; k < NTERM; k++) begin
      acc_d = acc_d + ACC_W'(coef_q[k]) * ACC_W'(p_i[k]);
      if (coef_q[k] != '0) coef_zero = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTERM; k++) coef_q[k] <= '0;
      v_q   <= 1'b0;
      x_q   <= '0;
      acc_q <= '0;
    end else begin
      for (int k = 0; k < NTERM; k++) coef_q[k] <= coef_d[k];
      v_q <= v_i;
      if (v_i) begin
        x_q   <= x_i;
        acc_q <= acc_d;
      end
    end
  end

  assign v_o   = v_q;
  assign x_o   = x_q;
  assign acc_o = acc_q;

  AST_ZERO_COEF_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && coef_zero) |=> (acc_q == '0)); // R6
endmodule

// File: rtl/dyn_lin_corr.sv
`timescale 1ns/1ps
module dyn_lin_corr
  import dlc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [13:0] in_sample,
  input  logic        coef_we,
  input  logic [2:0]  coef_sel,
  input  logic [15:0] coef_wdata,
  output logic        out_valid,
  output logic [13:0] out_sample
);
  logic  v2, v4, v5;
  samp_t x2, s2, x4, x5;
  prod_t terms [NTERM];
  logic signed [ACC_W-1:0] acc5;
  logic signed [47:0] corr, sum;
  samp_t out_d, out_q;
  logic  out_v_q;

  dlc_slope u_slope (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(samp_t'(in_sample)),
    .v_o(v2), .x_o(x2), .s_o(s2)
  );

  dlc_terms u_terms (
    .clk(clk), .rst_n(rst_n), .v_i(v2), .x_i(x2), .s_i(s2),
    .v_o(v4), .x_o(x4), .p_o(terms)
  );

  dlc_weight u_weight (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_t'(coef_wdata)), .v_i(v4), .x_i(x4), .p_i(terms),
    .v_o(v5), .x_o(x5), .acc_o(acc5)
  );

  // rounding and output saturation
  always_comb begin
    corr  = (48'(acc5) + (48'sd1 <<< (OUT_SH - 1))) >>> OUT_SH;
    sum   = 48'(x5) + corr;
    out_d = sat_samp(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      out_v_q <= v5;
      if (v5) out_q <= out_d;
    end
  end

  assign out_valid  = out_v_q;
  assign out_sample = out_q;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##6 out_valid); // R2
  AST_BUBBLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##6 !out_valid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v5 |=> $stable(out_sample)); // R7
endmodule

// File: tb/test_dyn_lin_corr.sv
`timescale 1ns/1ps
module test_dyn_lin_corr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [13:0] in_sample;
  logic        coef_we;
  logic [2:0]  coef_sel;
  logic [15:0] coef_wdata;
  logic        out_valid;
  logic [13:0] out_sample;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string req      = "R1";

  longint mh [7];
  longint mc [6];
  bit     ev [6];
  int     ed [6];

  always #4 clk = ~clk;

  dyn_lin_corr i_dyn_lin_corr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic longint sat(input longint v, input longint lo, input longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int model_out();
    longint raw, s, x, sqx, sqs, xs, cub, sxx, xss, acc;
    raw = 45 * (mh[2] - mh[4]) - 9 * (mh[1] - mh[5]) + (mh[0] - mh[6]);
    s   = sat((raw * 17) >>> 10, -8192, 8191);
    x   = mh[3];
    sqx = sat((x * x) >>> 11, -32768, 32767);
    sqs = sat((s * s) >>> 11, -32768, 32767);
    xs  = sat((x * s) >>> 11, -32768, 32767);
    cub = sat((sqx * x) >>> 13, -32768, 32767);
    sxx = sat((sqx * s) >>> 13, -32768, 32767);
    xss = sat((sqs * x) >>> 13, -32768, 32767);
    acc = mc[0] * sqx + mc[1] * cub + mc[2] * sxx + mc[3] * sqs + mc[4] * xss + mc[5] * xs;
    return int'(sat(x + ((acc + 65536) >>> 17), -8192, 8191));
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 7; k++) mh[k] = 0;
    for (int k = 0; k < 6; k++) begin mc[k] = 0; ev[k] = 0; ed[k] = 0; end
  endtask

  // one clock: compare, advance model, drive next inputs; called at a negedge
  task automatic cyc(input bit v, input int x, input bit we, input int sel, input int wd);
    n_checks++;
    if (out_valid !== ev[5]) begin
      n_fail++;
      $display("FAIL %s out_valid actual %b expected %b", req, out_valid, ev[5]);
    end
    if (ev[5]) begin
      n_checks++;
      if ($signed(out_sample) !== ed[5]) begin
        n_fail++;
        $display("FAIL %s out_sample actual %0d expected %0d", req, $signed(out_sample), ed[5]);
      end
    end
    for (int k = 5; k > 0; k--) begin ev[k] = ev[k-1]; ed[k] = ed[k-1]; end
    ev[0] = v;
    ed[0] = 0;
    if (v) begin
      for (int k = 6; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = x;
      ed[0] = model_out();
    end
    if (we && sel < 6) mc[sel] = wd;
    in_valid   = v;
    in_sample  = 14'(x);
    coef_we    = we;
    coef_sel   = 3'(sel);
    coef_wdata = 16'(wd);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int sel, input int wd);
    cyc(0, 0, 1, sel, wd);
  endtask

  function automatic int tri_wave(input int k, input int step);
    int t;
    t = (k * step) % 32768;
    return (t < 16384) ? t - 8192 : 24575 - t;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 0; in_sample = 0; coef_we = 0; coef_sel = 0; coef_wdata = 0;
    model_clear();
    req = "R1";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_sample !== 14'd0) begin
        n_fail++;
        $display("FAIL R1 reset outputs actual %b/%0d expected 0/0", out_valid, out_sample);
      end
    end
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R6 exact pass-through with zero coefficients (also shows R1 coefficients cleared)
    req = "R6";
    for (int i = 0; i < 40; i++) cyc(1, $urandom_range(16383) - 8192, 0, 0, 0);
    cyc(1, 8191, 0, 0, 0); cyc(1, -8192, 0, 0, 0);
    idle(8);
    // R2 bubbles: history must not advance on idle clocks
    req = "R2";
    wr(3, 30000);
    idle(8);
    for (int i = 0; i < 60; i++) cyc((i % 3) != 1, tri_wave(i, 900), 0, 0, 0);
    idle(8);
    wr(3, 0);
    // R3 R4 R5: one term at a time, fast triangle wave drives large slopes
    req = "R3 R4 R5";
    for (int t = 0; t < 6; t++) begin
      for (int k = 0; k < 6; k++) wr(k, 0);
      wr(t, (t % 2) ? -25000 : 28000);
      idle(8);
      for (int i = 0; i < 50; i++) cyc(1, tri_wave(i + 7 * t, 1300 + 200 * t), 0, 0, 0);
      for (int i = 0; i < 10; i++) cyc(1, $urandom_range(16383) - 8192, 0, 0, 0);
      cyc(1, -8192, 0, 0, 0); cyc(1, -8192, 0, 0, 0); cyc(1, 8191, 0, 0, 0);
      idle(8);
    end
    // R8: selects 6 and 7 are ignored
    req = "R8";
    for (int k = 0; k < 6; k++) wr(k, 0);
    wr(6, 32767);
    wr(7, -32768);
    idle(8);
    for (int i = 0; i < 30; i++) cyc(1, tri_wave(i, 2100), 0, 0, 0);
    idle(8);
    // R7 output saturation at both rails
    req = "R7";
    wr(0, 32767); wr(1, 32767); wr(3, 32767);
    idle(8);
    for (int i = 0; i < 30; i++) cyc(1, (i % 2) ? 8191 : -8192, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 8191, 0, 0, 0);
    idle(8);
    wr(0, -32768); wr(1, -32768); wr(3, -32768);
    idle(8);
    for (int i = 0; i < 20; i++) cyc(1, (i % 2) ? -8192 : 8191, 0, 0, 0);
    idle(8);
    // R9 history zero after reset: step from zero seen through s^2 and x*s
    do_reset();
    @(negedge clk);
    req = "R9";
    wr(3, 32767); wr(5, -20000);
    idle(8);
    for (int i = 0; i < 12; i++) cyc(1, 8000, 0, 0, 0);
    idle(8);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule